// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes a single asynchronous serial line and turns each frame on it into a 7-bit character for a host. A frame is one low start bit, seven data bits with the least significant bit first, one parity bit and one high stop bit. The block reports the character with two separate error flags: one for a parity mismatch and one for a stop bit that was sampled low.

The incoming line first passes through a two-flop synchronizer. Bit timing comes from a tick at sixteen times the bit rate. A falling edge on an idle line restarts both the tick divider and the tick count, so timing errors cannot build up from one frame to the next. The start bit is checked again at its midpoint, and a line that is high again there is treated as noise. Every later bit is sampled sixteen ticks after the previous one, which puts each sample near the middle of its bit.

A finished frame raises `rx_valid`. The character and flags are held until the host pulses `rx_ack`. A new frame may begin right after the previous stop bit, with no idle time between them.

Top module: `uart_rx_top`

## Requirements
- R1: A frame on `rx_line` (idle high, start 0, 7 data bits with bit 0 first, parity, stop 1) delivers its 7 data bits on `rx_data`, with bit 0 being the first data bit received.
- R2: With `parity_odd`=0 the data bits plus the parity bit must hold an even number of ones, and with `parity_odd`=1 an odd number. A mismatch sets `rx_par_err` with the character. `parity_odd` is sampled when the stop bit is sampled.
- R3: A stop bit sampled as 0 sets `rx_frm_err`. The character and the parity result are still reported with it.
- R4: A low pulse on `rx_line` that has ended before the middle of the start bit produces no character. A proper frame that follows it is received normally.
- R5: A start bit that directly follows a stop bit, with no idle time, is received as a new frame.
- R6: Frames whose bit period differs from the nominal 16*CLKS_PER_TICK clocks by up to 3% are received correctly.
- R7: `rx_valid` and the character stay unchanged until `rx_ack` is sampled high. That edge clears `rx_valid` and both error flags, and `rx_data` keeps its value. `rx_ack` while `rx_valid` is low has no effect.
- R8: If a frame completes on the same clock edge on which `rx_ack` is sampled, `rx_valid` stays high and carries the new character.
- R9: A synchronous active-high `rst` clears `rx_valid`, `rx_data` and both flags and returns the receiver to idle.
- R10: `rx_valid` rises 9.5 bit periods after the falling start edge, give or take no more than 8 clocks of synchronizer and divider delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| parity_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| rx_ack | input | 1 | Host acknowledge; clears the held character |
| rx_valid | output | 1 | A received character is held |
| rx_data | output | 7 | Received character |
| rx_par_err | output | 1 | Parity mismatch on the held character |
| rx_frm_err | output | 1 | Stop bit of the held character was 0 |

## Verification
The case that needs care is a frame completing on the same clock edge on which the host acknowledges the previous character. The clearing path and the loading path then compete for the same register. The bench first measures, in clocks, how long a frame takes from its start edge to `rx_valid`. It then sends a second frame directly behind an unacknowledged one and raises `rx_ack` so that it is sampled on exactly that completion edge. The result is judged by `rx_valid` staying high and `rx_data` holding the second character. A later single acknowledge must then clear it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W     = 7;
    localparam int OVERSAMPLE = 16;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_result_t;

    // 1 when data plus parity bit do not match the selected parity sense
    function automatic logic parity_mismatch(input logic [CHAR_W-1:0] d,
                                             input logic              pbit,
                                             input logic              odd);
        return ((^d) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int CLKS_PER_TICK = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    generate
        if (CLKS_PER_TICK <= 1) begin : g_every
            assign tick = ~clr;
        end else begin : g_div
            localparam int CW = $clog2(CLKS_PER_TICK);
            localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || clr)      cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end

            assign tick = (cnt == LAST) && !clr;
        end
    endgenerate
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OSR = OVERSAMPLE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_s,
    input  logic       tick,
    input  logic       odd_sel,
    output logic       tick_clr,
    output logic       done,
    output rx_result_t result
);
    localparam int TW = $clog2(OSR);
    localparam int BW = $clog2(CHAR_W);
    localparam logic [TW-1:0] HALF_LAST = TW'(OSR / 2 - 1);
    localparam logic [TW-1:0] FULL_LAST = TW'(OSR - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(CHAR_W - 1);

    rx_state_e         state;
    logic [TW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [CHAR_W-1:0] shreg;
    logic              pbit;
    logic              prev;
    logic              fall;
    logic              at_mid;

    assign fall     = prev && !rx_s;
    assign tick_clr = (state == RX_IDLE) && fall;
    assign at_mid   = tick && (tcnt == FULL_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            tcnt   <= '0;
            bidx   <= '0;
            shreg  <= '0;
            pbit   <= 1'b0;
            prev   <= 1'b1;
            done   <= 1'b0;
            result <= '0;
        end else begin
            prev <= rx_s;
            done <= 1'b0;
            if (tick && state != RX_IDLE)
                tcnt <= (tcnt == FULL_LAST) ? '0 : tcnt + 1'b1;
            case (state)
                RX_IDLE: begin
                    if (fall) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: begin
                    if (tick && tcnt == HALF_LAST) begin
                        tcnt  <= '0;
                        bidx  <= '0;
                        state <= rx_s ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (at_mid) begin
                        shreg <= {rx_s, shreg[CHAR_W-1:1]};
                        bidx  <= bidx + 1'b1;
                        if (bidx == BIT_LAST) state <= RX_PAR;
                    end
                end
                RX_PAR: begin
                    if (at_mid) begin
                        pbit  <= rx_s;
                        state <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (at_mid) begin
                        done           <= 1'b1;
                        result.data    <= shreg;
                        result.par_err <= parity_mismatch(shreg, pbit, odd_sel);
                        result.frm_err <= !rx_s;
                        state          <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_hold.sv
module rx_hold
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  rx_result_t din,
    input  logic       ack,
    output logic       valid,
    output rx_result_t dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (ack && valid) begin
            valid        <= 1'b0;
            dout.par_err <= 1'b0;
            dout.frm_err <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
    import uart_rx_pkg::*;
#(
    parameter int CLKS_PER_TICK = 27,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              parity_odd,
    input  logic              rx_ack,
    output logic              rx_valid,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_par_err,
    output logic              rx_frm_err
);
    logic       rx_s;
    logic       tick;
    logic       tick_clr;
    logic       frame_done;
    rx_result_t frame_res;
    rx_result_t held;

    rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .din (rx_line),
        .dout(rx_s)
    );

    rx_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) tick_i (
        .clk (clk),
        .rst (rst),
        .clr (tick_clr),
        .tick(tick)
    );

    rx_frame_fsm #(.OSR(OVERSAMPLE)) fsm_i (
        .clk     (clk),
        .rst     (rst),
        .rx_s    (rx_s),
        .tick    (tick),
        .odd_sel (parity_odd),
        .tick_clr(tick_clr),
        .done    (frame_done),
        .result  (frame_res)
    );

    rx_hold hold_i (
        .clk  (clk),
        .rst  (rst),
        .load (frame_done),
        .din  (frame_res),
        .ack  (rx_ack),
        .valid(rx_valid),
        .dout (held)
    );

    assign rx_data    = held.data;
    assign rx_par_err = held.par_err;
    assign rx_frm_err = held.frm_err;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk
    import uart_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_ack,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_data,
    input logic              rx_par_err,
    input logic              rx_frm_err,
    input logic              done
);
    // R9: reset leaves nothing pending
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!rx_valid && !rx_par_err && !rx_frm_err && rx_data == '0));

    // R7: held character does not move without an acknowledge
    p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ack && !done) |=> (rx_valid && $stable(rx_data)
                                            && $stable(rx_par_err) && $stable(rx_frm_err)));

    // R7: acknowledge clears valid and flags
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ack && !done) |=> (!rx_valid && !rx_par_err && !rx_frm_err));

    // R8: completion always leaves a character pending, acknowledge or not
    p_done_wins_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> rx_valid);

    // R1: a frame completion is a single-cycle event
    p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2 / R3: error flags only accompany a held character
    p_flags_need_valid_r3: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> (!rx_par_err && !rx_frm_err));
endmodule

bind uart_rx_top uart_rx_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .rx_ack    (rx_ack),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err),
    .done      (frame_done)
);

// File: tb/uart_rx_top_tb_top.sv
`timescale 1ns/1ps
module uart_rx_top_tb_top;
    localparam int CPT = 4;
    localparam int BIT = 16 * CPT;
    localparam int LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       parity_odd = 1'b0;
    logic       mon_ack = 1'b0;
    logic       man_ack = 1'b0;
    logic       rx_ack;
    logic       rx_valid;
    logic [6:0] rx_data;
    logic       rx_par_err;
    logic       rx_frm_err;

    int n_chk = 0;
    int n_fail = 0;
    int exp_n = 0;
    int got_n = 0;
    bit auto_ack = 1'b0;
    int lat = 0;

    int    exp_d  [0:255];
    int    exp_pe [0:255];
    int    exp_fe [0:255];
    string exp_req[0:255];

    assign rx_ack = mon_ack | man_ack;

    always #5 clk = ~clk;

    uart_rx_top #(.CLKS_PER_TICK(CPT)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .parity_odd(parity_odd),
        .rx_ack    (rx_ack),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // frame sender; must be called on a negative edge
    task automatic send(input logic [6:0] d, input logic pbit, input logic stopb,
                        input int bclk, input int idle_bits);
        rx_line = 1'b0;
        repeat (bclk) @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            rx_line = d[i];
            repeat (bclk) @(negedge clk);
        end
        rx_line = pbit;
        repeat (bclk) @(negedge clk);
        rx_line = stopb;
        repeat (bclk) @(negedge clk);
        rx_line = 1'b1;
        repeat (idle_bits * bclk) @(negedge clk);
    endtask

    task automatic expect_frame(input int d, input int pe, input int fe, input string req);
        exp_d[exp_n]   = d;
        exp_pe[exp_n]  = pe;
        exp_fe[exp_n]  = fe;
        exp_req[exp_n] = req;
        exp_n++;
    endtask

    function automatic logic good_par(input logic [6:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // auto-acknowledging monitor
    always @(negedge clk) begin
        if (!rst && auto_ack && rx_valid && !mon_ack) begin
            if (got_n >= exp_n) begin
                chk("R1 unexpected frame", 1, 0);
            end else begin
                chk({exp_req[got_n], " data"}, int'(rx_data), exp_d[got_n]);
                chk({exp_req[got_n], " parity flag (R2)"}, int'(rx_par_err), exp_pe[got_n]);
                chk({exp_req[got_n], " framing flag (R3)"}, int'(rx_frm_err), exp_fe[got_n]);
            end
            got_n++;
            mon_ack <= 1'b1;
        end else begin
            mon_ack <= 1'b0;
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", LIMIT);
        summary();
        $finish;
    end

    initial begin
        int got_before;
        repeat (5) @(negedge clk);
        // R9: reset state
        chk("R9 valid after reset", int'(rx_valid), 0);
        chk("R9 data after reset", int'(rx_data), 0);
        chk("R9 parity flag after reset", int'(rx_par_err), 0);
        chk("R9 framing flag after reset", int'(rx_frm_err), 0);
        rst = 1'b0;
        repeat (BIT) @(negedge clk);

        // R10 latency, R1 data, R7 hold and acknowledge
        fork
            send(7'h5A, good_par(7'h5A, 1'b0), 1'b1, BIT, 1);
            begin
                lat = 0;
                while (!rx_valid && lat < 2000) begin
                    @(negedge clk);
                    lat++;
                end
            end
        join
        chk("R10 latency in window", int'(lat >= BIT * 19 / 2 && lat <= BIT * 19 / 2 + 8), 1);
        chk("R1 first character", int'(rx_data), 'h5A);
        chk("R2 even parity clean", int'(rx_par_err), 0);
        repeat (300) @(negedge clk);
        chk("R7 valid held without ack", int'(rx_valid), 1);
        chk("R7 data held without ack", int'(rx_data), 'h5A);
        man_ack = 1'b1;
        @(negedge clk);
        man_ack = 1'b0;
        chk("R7 ack clears valid", int'(rx_valid), 0);
        chk("R7 data kept after ack", int'(rx_data), 'h5A);
        man_ack = 1'b1;
        @(negedge clk);
        man_ack = 1'b0;
        chk("R7 ack while idle ignored", int'(rx_valid), 0);

        // R8: completion on the acknowledge edge, back-to-back frames (R5)
        send(7'h55, good_par(7'h55, 1'b0), 1'b1, BIT, 0);
        chk("R8 first frame pending", int'(rx_valid), 1);
        fork
            send(7'h2A, good_par(7'h2A, 1'b0), 1'b1, BIT, 1);
            begin
                repeat (lat - 1) @(negedge clk);
                man_ack = 1'b1;
                @(negedge clk);
                man_ack = 1'b0;
            end
        join
        chk("R8 valid kept on coincident ack", int'(rx_valid), 1);
        chk("R8 new character held", int'(rx_data), 'h2A);
        man_ack = 1'b1;
        @(negedge clk);
        man_ack = 1'b0;
        chk("R8 later ack clears", int'(rx_valid), 0);

        auto_ack = 1'b1;

        // R6: bit period off by about 3% either way
        expect_frame('h3C, 0, 0, "R6 slow line");
        send(7'h3C, good_par(7'h3C, 1'b0), 1'b1, BIT + 2, 1);
        expect_frame('h43, 0, 0, "R6 fast line");
        send(7'h43, good_par(7'h43, 1'b0), 1'b1, BIT - 2, 1);

        // R4: short low glitch, then a real frame
        got_before = got_n;
        rx_line = 1'b0;
        repeat (BIT / 4) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        chk("R4 glitch gives no character", got_n, got_before);
        chk("R4 glitch leaves valid low", int'(rx_valid), 0);
        expect_frame('h11, 0, 0, "R4 frame after glitch");
        send(7'h11, good_par(7'h11, 1'b0), 1'b1, BIT, 1);

        // sweep of every character: R1, R2, R3, R5
        for (int i = 0; i < 128; i++) begin
            logic [6:0] d;
            logic       sel;
            logic       bad_p;
            logic       bad_s;
            string      tag;
            d     = 7'(i);
            sel   = d[0];
            bad_p = (i % 3) == 0;
            bad_s = (i % 5) == 0;
            tag   = bad_s ? "R3 sweep" : (bad_p ? "R2 sweep" : "R5 sweep R1");
            parity_odd = sel;
            expect_frame(i, int'(bad_p), int'(bad_s), tag);
            send(d, good_par(d, sel) ^ bad_p, ~bad_s, BIT, bad_s ? 1 : 0);
        end
        repeat (2 * BIT) @(negedge clk);
        chk("R1 frames received", got_n, exp_n);

        summary();
        $finish;
    end
endmodule